// File: doc/BRIEF.md
# Display Serial Bus Command/Data Transmitter

This block is the host side of a write-only serial link to a display panel controller. Command and data bytes arrive over a valid/ready handshake. Each byte carries a flag that marks it as a command (flag 0) or as data (flag 1). The block wraps every byte in one of three wire framings and shifts it out on a chip select, a serial clock and a serial data line. It also drives a separate data/command line and an active-low panel reset output.

The framing is set by a static `mode_i` input. Two framings carry the command/data flag inside the serial word, so the panel needs only three wires. The third framing sends the bare byte and relies on the separate data/command line. The serial clock follows SPI mode 0: it idles low, data changes while the clock is low, and the panel samples on the rising edge. One clock period lasts `2 * half_div_i` system clocks.

A one-cycle `rst_req_i` starts a panel reset sequence. The reset output is held low for a programmed time, and then the block stays closed to new bytes for a programmed recovery time. The panel is never read back.

Top module: `dbus_tx`

## Requirements
- R1: With `mode_i` = 0, each frame has 9 rising serial clock edges. The flag bit goes first (0 = command, 1 = data), then the byte, most significant bit first.
- R2: With `mode_i` = 1, each frame has 16 rising serial clock edges: seven 0 filler bits, then the flag bit, then the byte, most significant bit first.
- R3: With `mode_i` = 2 or 3, each frame has 8 rising serial clock edges carrying the byte, most significant bit first. `dc_o` shows the flag (1 = data).
- R4: In every mode, `dc_o` equals the byte's flag from at least one half clock period before `cs_n_o` falls until after `cs_n_o` rises, and it stays stable while `cs_n_o` is low.
- R5: `sclk_o` is low whenever `cs_n_o` is high, and `sdo_o` changes only while `sclk_o` is low. Consecutive rising edges are `2 * half_div_i` system clocks apart, and `half_div_i` = 0 behaves as 1.
- R6: `cs_n_o` stays low for a whole frame. Between two frames it stays high for at least one serial clock period.
- R7: `in_ready_o` is high only when no frame is in progress and the reset sequence is finished. A byte is taken only on a cycle where both `in_valid_i` and `in_ready_o` are high.
- R8: A `rst_req_i` pulse drives `panel_rst_n_o` low for exactly `rst_low_i` cycles (0 behaves as 1). `in_ready_o` then stays low for exactly `rst_wait_i` more cycles.
- R9: After the synchronous reset `rst`, `cs_n_o` = 1, `sclk_o` = 0, `panel_rst_n_o` = 1 and `in_ready_o` = 1.
- R10: A byte offered while the panel reset sequence runs starts no frame until `in_ready_o` rises, and it is then sent once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| mode_i | input | 2 | Framing: 0 = 9-bit, 1 = 16-bit, 2/3 = 8-bit with separate flag line |
| half_div_i | input | DIV_W | Serial clock half period in system clocks |
| rst_req_i | input | 1 | Starts the panel reset sequence |
| rst_low_i | input | RST_W | Cycles the panel reset output is held low |
| rst_wait_i | input | RST_W | Recovery cycles before bytes are accepted again |
| in_valid_i | input | 1 | Byte offered |
| in_ready_o | output | 1 | Byte can be taken |
| in_byte_i | input | 8 | Byte to send |
| in_is_data_i | input | 1 | 1 = data, 0 = command |
| cs_n_o | output | 1 | Chip select, active low |
| sclk_o | output | 1 | Serial clock |
| sdo_o | output | 1 | Serial data out |
| dc_o | output | 1 | Data/command line, 1 = data |
| panel_rst_n_o | output | 1 | Panel reset, active low |

## Verification
The bench records each frame as the panel would see it: it samples `sdo_o` on every rising serial clock edge while chip select is low. A design that mis-ordered the flag or the filler, or that shifted one bit too many or too few, would show a wrong word or a wrong edge count.

The corner cases are a zero half-period setting, the alias mode 3, and back-to-back frames. The bench measures the chip select gap and the serial clock period in time. A short gap or a divider off by one shows up there.

The reset sequence is timed cycle by cycle, including a zero low length. A byte is held on the handshake during the whole sequence, which catches a design that leaks a frame through before recovery ends or sends the byte twice.

// File: rtl/dbus_tx_pkg.sv
`timescale 1ns/1ps
package dbus_tx_pkg;
  localparam int FRAME_W = 16;
  localparam int LEN_W   = 5;

  typedef enum logic [1:0] {
    FM_NINE      = 2'd0,
    FM_SIXTEEN   = 2'd1,
    FM_EIGHT     = 2'd2,
    FM_EIGHT_ALT = 2'd3
  } frame_mode_e;

  typedef enum logic [2:0] {
    SH_IDLE, SH_SETUP, SH_LOW, SH_HIGH, SH_GAP
  } shift_state_e;

  typedef enum logic [1:0] {
    RS_DONE, RS_LOW, RS_WAIT
  } rst_state_e;

  // Serial word, left aligned: bit FRAME_W-1 leaves first.
  function automatic logic [FRAME_W-1:0] frame_word(frame_mode_e m, logic is_data,
                                                    logic [7:0] b);
    case (m)
      FM_NINE:    return {is_data, b, 7'b0};
      FM_SIXTEEN: return {7'b0, is_data, b};
      default:    return {b, 8'b0};
    endcase
  endfunction

  function automatic logic [LEN_W-1:0] frame_len(frame_mode_e m);
    case (m)
      FM_NINE:    return 5'd9;
      FM_SIXTEEN: return 5'd16;
      default:    return 5'd8;
    endcase
  endfunction
endpackage

// File: rtl/dbus_tx_clkgen.sv
`timescale 1ns/1ps
module dbus_tx_clkgen #(
  parameter int DIV_W = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             restart_i,
  input  logic [DIV_W-1:0] half_div_i,
  output logic             tick_o
);
  localparam logic [DIV_W-1:0] ONE = DIV_W'(1);

  logic [DIV_W-1:0] cnt;
  logic [DIV_W-1:0] reload;

  // A zero half period behaves as one cycle.
  assign reload = (half_div_i == '0) ? '0 : half_div_i - ONE;
  assign tick_o = (cnt == '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt <= '0;
    end else if (restart_i || cnt == '0) begin
      cnt <= reload;
    end else begin
      cnt <= cnt - ONE;
    end
  end
endmodule

// File: rtl/dbus_tx_shifter.sv
`timescale 1ns/1ps
module dbus_tx_shifter
  import dbus_tx_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic        tick_i,
  input  logic        start_i,
  input  frame_mode_e mode_i,
  input  logic        is_data_i,
  input  logic [7:0]  byte_i,
  output logic        idle_o,
  output logic        cs_n_o,
  output logic        sclk_o,
  output logic        sdo_o,
  output logic        dc_o
);
  shift_state_e       state;
  logic [FRAME_W-1:0] word;
  logic [LEN_W-1:0]   bits_left;
  logic [LEN_W-1:0]   len_q;
  logic               gap_second;

  assign idle_o = (state == SH_IDLE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= SH_IDLE;
      word       <= '0;
      bits_left  <= '0;
      len_q      <= '0;
      gap_second <= 1'b0;
      cs_n_o     <= 1'b1;
      sclk_o     <= 1'b0;
      sdo_o      <= 1'b0;
      dc_o       <= 1'b0;
    end else begin
      case (state)
        SH_IDLE: if (start_i) begin
          word  <= frame_word(mode_i, is_data_i, byte_i);
          len_q <= frame_len(mode_i);
          dc_o  <= is_data_i;
          state <= SH_SETUP;
        end
        SH_SETUP: if (tick_i) begin
          cs_n_o    <= 1'b0;
          sdo_o     <= word[FRAME_W-1];
          word      <= word << 1;
          bits_left <= len_q - 5'd1;
          state     <= SH_LOW;
        end
        SH_LOW: if (tick_i) begin
          sclk_o <= 1'b1;
          state  <= SH_HIGH;
        end
        SH_HIGH: if (tick_i) begin
          sclk_o <= 1'b0;
          if (bits_left == '0) begin
            cs_n_o     <= 1'b1;
            sdo_o      <= 1'b0;
            gap_second <= 1'b0;
            state      <= SH_GAP;
          end else begin
            sdo_o     <= word[FRAME_W-1];
            word      <= word << 1;
            bits_left <= bits_left - 5'd1;
            state     <= SH_LOW;
          end
        end
        SH_GAP: if (tick_i) begin
          if (gap_second) state <= SH_IDLE;
          else            gap_second <= 1'b1;
        end
        default: state <= SH_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/dbus_tx_rstseq.sv
`timescale 1ns/1ps
module dbus_tx_rstseq
  import dbus_tx_pkg::*;
#(
  parameter int RST_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             req_i,
  input  logic [RST_W-1:0] low_len_i,
  input  logic [RST_W-1:0] wait_len_i,
  output logic             panel_rst_n_o,
  output logic             done_o
);
  localparam logic [RST_W-1:0] ONE = RST_W'(1);

  rst_state_e       state;
  logic [RST_W-1:0] cnt;

  assign done_o = (state == RS_DONE);

  always_ff @(posedge clk) begin
    if (rst) begin
      state         <= RS_DONE;
      cnt           <= '0;
      panel_rst_n_o <= 1'b1;
    end else if (req_i) begin
      state         <= RS_LOW;
      cnt           <= (low_len_i == '0) ? '0 : low_len_i - ONE;
      panel_rst_n_o <= 1'b0;
    end else begin
      case (state)
        RS_LOW: if (cnt == '0) begin
          panel_rst_n_o <= 1'b1;
          if (wait_len_i == '0) begin
            state <= RS_DONE;
          end else begin
            state <= RS_WAIT;
            cnt   <= wait_len_i - ONE;
          end
        end else begin
          cnt <= cnt - ONE;
        end
        RS_WAIT: if (cnt == '0) state <= RS_DONE;
                 else           cnt   <= cnt - ONE;
        default: state <= RS_DONE;
      endcase
    end
  end
endmodule

// File: rtl/dbus_tx.sv
`timescale 1ns/1ps
module dbus_tx
  import dbus_tx_pkg::*;
#(
  parameter int DIV_W = 8,
  parameter int RST_W = 16
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [1:0]       mode_i,
  input  logic [DIV_W-1:0] half_div_i,
  input  logic             rst_req_i,
  input  logic [RST_W-1:0] rst_low_i,
  input  logic [RST_W-1:0] rst_wait_i,
  input  logic             in_valid_i,
  output logic             in_ready_o,
  input  logic [7:0]       in_byte_i,
  input  logic             in_is_data_i,
  output logic             cs_n_o,
  output logic             sclk_o,
  output logic             sdo_o,
  output logic             dc_o,
  output logic             panel_rst_n_o
);
  logic tick, start, sh_idle, seq_done;

  assign in_ready_o = sh_idle & seq_done;
  assign start      = in_valid_i & in_ready_o;

  dbus_tx_clkgen #(.DIV_W(DIV_W)) u_clkgen (
    .clk(clk), .rst(rst), .restart_i(start),
    .half_div_i(half_div_i), .tick_o(tick)
  );

  dbus_tx_shifter u_shifter (
    .clk(clk), .rst(rst), .tick_i(tick), .start_i(start),
    .mode_i(frame_mode_e'(mode_i)), .is_data_i(in_is_data_i), .byte_i(in_byte_i),
    .idle_o(sh_idle), .cs_n_o(cs_n_o), .sclk_o(sclk_o), .sdo_o(sdo_o), .dc_o(dc_o)
  );

  dbus_tx_rstseq #(.RST_W(RST_W)) u_rstseq (
    .clk(clk), .rst(rst), .req_i(rst_req_i),
    .low_len_i(rst_low_i), .wait_len_i(rst_wait_i),
    .panel_rst_n_o(panel_rst_n_o), .done_o(seq_done)
  );
endmodule

// File: rtl/dbus_tx_chk.sv
`timescale 1ns/1ps
module dbus_tx_chk (
  input logic clk,
  input logic rst,
  input logic in_ready_o,
  input logic cs_n_o,
  input logic sclk_o,
  input logic sdo_o,
  input logic dc_o,
  input logic panel_rst_n_o
);
  a_r5_sclk_low_deselected: assert property (@(posedge clk) disable iff (rst)
    cs_n_o |-> !sclk_o);

  a_r5_sdo_stable_sclk_high: assert property (@(posedge clk) disable iff (rst)
    (sclk_o && $past(sclk_o)) |-> $stable(sdo_o));

  a_r4_dc_stable_in_frame: assert property (@(posedge clk) disable iff (rst)
    (!cs_n_o && !$past(cs_n_o)) |-> $stable(dc_o));

  a_r7_busy_not_ready: assert property (@(posedge clk) disable iff (rst)
    !cs_n_o |-> !in_ready_o);

  a_r8_reset_blocks_ready: assert property (@(posedge clk) disable iff (rst)
    !panel_rst_n_o |-> !in_ready_o);

  a_r6_cs_rise_stays_high: assert property (@(posedge clk) disable iff (rst)
    $rose(cs_n_o) |=> cs_n_o);
endmodule

bind dbus_tx dbus_tx_chk u_chk (
  .clk(clk), .rst(rst), .in_ready_o(in_ready_o), .cs_n_o(cs_n_o),
  .sclk_o(sclk_o), .sdo_o(sdo_o), .dc_o(dc_o), .panel_rst_n_o(panel_rst_n_o)
);

// File: tb/dbus_tx_tb.sv
`timescale 1ns/1ps
module dbus_tx_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [1:0]  mode = 2'd0;
  logic [7:0]  half_div = 8'd1;
  logic        rst_req = 1'b0;
  logic [15:0] rst_low = 16'd1;
  logic [15:0] rst_wait = 16'd0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [7:0]  in_byte = 8'h00;
  logic        in_is_data = 1'b0;
  logic        cs_n, sclk, sdo, dc, panel_rst_n;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  always #5 clk = ~clk;

  dbus_tx u_dut (
    .clk(clk), .rst(rst), .mode_i(mode), .half_div_i(half_div),
    .rst_req_i(rst_req), .rst_low_i(rst_low), .rst_wait_i(rst_wait),
    .in_valid_i(in_valid), .in_ready_o(in_ready), .in_byte_i(in_byte),
    .in_is_data_i(in_is_data), .cs_n_o(cs_n), .sclk_o(sclk), .sdo_o(sdo),
    .dc_o(dc), .panel_rst_n_o(panel_rst_n)
  );

  // Panel-side capture.
  logic [15:0] cap = '0;
  int  ncap = 0, frames = 0;
  time t_sclk = 0, period_last = 0, t_fall = 0, t_rise = 0, gap_last = 0;
  logic dc_fall = 0, dc_rise = 0;

  always @(posedge sclk) if (!cs_n) begin
    if (ncap > 0) period_last = $time - t_sclk;
    t_sclk = $time;
    cap = {cap[14:0], sdo};
    ncap++;
  end
  always @(negedge cs_n) begin
    cap = '0; ncap = 0; dc_fall = dc; t_fall = $time;
    if (frames > 0) gap_last = t_fall - t_rise;
  end
  always @(posedge cs_n) if (!rst) begin
    dc_rise = dc; t_rise = $time; frames++;
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  endtask

  task automatic send(input logic [1:0] m, input logic flag, input logic [7:0] b);
    int f0;
    f0 = frames;
    mode = m; in_is_data = flag; in_byte = b;
    @(negedge clk);
    while (!in_ready) @(negedge clk);
    in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk(in_ready == 1'b0, "R7 ready low while busy", in_ready, 0);
    wait (frames == f0 + 1);
    @(negedge clk);
  endtask

  // {mode, flag, byte, expected captured word, expected edge count}
  localparam logic [31:0] VEC [0:7] = '{
    {2'd0, 1'b0, 8'h2A, 16'h002A, 5'd9},
    {2'd0, 1'b1, 8'hA5, 16'h01A5, 5'd9},
    {2'd1, 1'b0, 8'h36, 16'h0036, 5'd16},
    {2'd1, 1'b1, 8'hFF, 16'h01FF, 5'd16},
    {2'd2, 1'b0, 8'h11, 16'h0011, 5'd8},
    {2'd2, 1'b1, 8'h80, 16'h0080, 5'd8},
    {2'd0, 1'b1, 8'h00, 16'h0100, 5'd9},
    {2'd1, 1'b0, 8'h00, 16'h0000, 5'd16}
  };

  initial begin
    #(10 * 150000);
    errors++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    int lo, wt, f0;
    bit leak;
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk(cs_n == 1'b1, "R9 cs_n after reset", cs_n, 1);
    chk(sclk == 1'b0, "R9 sclk after reset", sclk, 0);
    chk(panel_rst_n == 1'b1, "R9 panel reset after reset", panel_rst_n, 1);
    chk(in_ready == 1'b1, "R9 ready after reset", in_ready, 1);

    for (int i = 0; i < 8; i++) begin
      logic [1:0] m; logic fl; logic [7:0] b; logic [15:0] ew; logic [4:0] en;
      {m, fl, b, ew, en} = VEC[i];
      half_div = (i < 4) ? 8'd1 : 8'd3;
      send(m, fl, b);
      if (m == 2'd0)      chk(cap == ew, "R1 nine-bit word", cap, ew);
      else if (m == 2'd1) chk(cap == ew, "R2 sixteen-bit word", cap, ew);
      else                chk(cap == ew, "R3 eight-bit word", cap, ew);
      chk(ncap == int'(en), "R1 R2 R3 edge count", ncap, en);
      chk(dc_fall == fl && dc_rise == fl, "R4 dc level across frame", {dc_fall, dc_rise}, {fl, fl});
      chk(period_last == time'(20 * half_div), "R5 sclk period", int'(period_last), 20 * half_div);
      if (i > 0) chk(gap_last >= time'(20 * half_div), "R6 cs gap", int'(gap_last), 20 * half_div);
    end

    // Alias mode 3 with a zero half period.
    half_div = 8'd0;
    send(2'd3, 1'b1, 8'h5C);
    chk(cap == 16'h005C && ncap == 8, "R3 alias mode word", cap, 16'h005C);
    chk(dc_rise == 1'b1, "R3 dc shows data", dc_rise, 1);
    chk(period_last == 20, "R5 zero half period", int'(period_last), 20);

    // Back-to-back frames.
    half_div = 8'd2;
    send(2'd2, 1'b0, 8'hC3);
    send(2'd2, 1'b0, 8'h3C);
    chk(gap_last >= 40, "R6 back-to-back gap", int'(gap_last), 40);
    chk(cap == 16'h003C, "R6 second frame word", cap, 16'h003C);

    // Panel reset sequence with a byte held waiting.
    rst_low = 16'd5; rst_wait = 16'd7; half_div = 8'd1;
    mode = 2'd0; in_byte = 8'h99; in_is_data = 1'b1;
    f0 = frames; leak = 0;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    in_valid = 1'b1;
    lo = 0; wt = 0;
    while (!panel_rst_n) begin lo++; if (!cs_n) leak = 1; @(negedge clk); end
    while (!in_ready)    begin wt++; if (!cs_n) leak = 1; @(negedge clk); end
    @(negedge clk);
    in_valid = 1'b0;
    chk(lo == 5, "R8 reset low cycles", lo, 5);
    chk(wt == 7, "R8 recovery cycles", wt, 7);
    chk(!leak && frames == f0, "R10 no frame during reset", frames - f0, 0);
    wait (frames == f0 + 1);
    repeat (40) @(negedge clk);
    chk(frames == f0 + 1 && cap == 16'h0199, "R10 held byte sent once", frames - f0, 1);

    // Zero low length, zero recovery.
    rst_low = 16'd0; rst_wait = 16'd0;
    rst_req = 1'b1;
    @(negedge clk);
    rst_req = 1'b0;
    lo = 0; wt = 0;
    while (!panel_rst_n) begin lo++; @(negedge clk); end
    while (!in_ready)    begin wt++; @(negedge clk); end
    chk(lo == 1, "R8 zero low length", lo, 1);
    chk(wt == 0, "R8 zero recovery", wt, 0);

    finish_run();
  end
endmodule